// File: doc/BRIEF.md
# Streaming 16-Point FFT with Feedback Delay Stages

This block computes a 16-point discrete Fourier transform on a continuous stream of complex samples. It accepts one sample per accepted clock and produces one result per accepted clock. Four radix-2 decimation-in-frequency stages are cascaded. Each stage has a feedback delay line of 8, 4, 2 or 1 words. During the first half of each block a stage stores incoming samples and drains its delay line. During the second half it forms sums, which it passes on, and differences, which it writes back into the delay line. The differences are rotated by a twiddle factor on their way out. Stage 1 and stage 2 use a real multiplier. Stage 3 only needs a swap and a negation. Stage 4 has no rotation.

A per-sample inverse flag conjugates the sample on entry and the result on exit. This turns the same datapath into an unscaled inverse transform. A frame-start flag marks sample 0 of each frame. It aligns the phase counters of all stages and travels with the data, so the result for bin 0 is marked at the output. The words never get narrower: every internal word and the output carry four guard bits above the input width, and no scaling is applied. Results leave in bit-reversed bin order. Reordering them into natural order is left to the consumer.

Top module: `fft16_sdf`

## Requirements
- R1: While reset is applied and after it is released, with no samples accepted yet, `out_valid` and `out_sof` are 0, and `out_re` and `out_im` are 0.
- R2: With `in_inv` = 0 for all samples of a frame, the output for bin k equals the sum over n of x[n]·e^(−j2πnk/16), unscaled, within ±16 LSB. The output is IN_W+4 bits wide. This holds when every input sample has a complex magnitude below 2^(IN_W−1).
- R3: Within a frame, output position p (0..15) carries bin bitrev4(p). For example, position 1 (0001) carries bin 8 (1000), and position 3 (0011) carries bin 12 (1100).
- R4: Counting accepted samples from reset as indices 0, 1, 2, …, the result for output-stream position p is presented on the cycle after input index p+18 is accepted. So the first result of a frame follows that frame's last sample by three accepted samples.
- R5: An accepted sample with `in_sof` = 1 starts a frame by restarting every stage's block phase. `out_sof` is 1 exactly on output position 0 of each frame, which is once every 16 valid outputs.
- R6: With `in_inv` = 1 for all samples of a frame, bin k equals the sum over n of x[n]·e^(+j2πnk/16), unscaled, within ±16 LSB. The output order and the timing are the same as for a forward frame.
- R7: A cycle with `in_valid` = 0 changes no state. On the following cycle `out_valid` is 0 and `out_re` and `out_im` hold their previous values.
- R8: `out_valid` is 1 only on the cycle after an accepted sample, and only once 18 samples have already been accepted since reset. After that point it is 1 after every accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample is accepted this cycle; also the pipeline advance enable |
| in_sof | input | 1 | Accepted sample is sample 0 of a frame |
| in_inv | input | 1 | Accepted sample belongs to an inverse-transform frame |
| in_re | input | IN_W | Input real part, signed |
| in_im | input | IN_W | Input imaginary part, signed |
| out_valid | output | 1 | One result is presented this cycle |
| out_sof | output | 1 | Presented result is position 0 (bin 0) of a frame |
| out_re | output | IN_W+4 | Result real part, signed |
| out_im | output | IN_W+4 | Result imaginary part, signed |

## Verification
Four properties are checked on every cycle. A valid output must follow an accepted input. Outputs must stay frozen across a stall. The frame-start token must leave each stage exactly when that stage enters its compute half. Output frame markers must recur every 16 valid results. The numerical result of each bin, the bit-reversed position of each bin, the 18-sample latency, and the inverse-mode conjugation can only be shown by the bench's scenarios. These compare every output against a behavioural DFT of the frames that were sent: impulse, constant, pure tones, random frames, frames near full scale, and frames broken up by stalls.

// File: rtl/fft16_pkg.sv
package fft16_pkg;

  localparam int FFT_LOG2N = 4;
  localparam int FFT_N     = 1 << FFT_LOG2N;
  localparam int TW_W      = 16;
  localparam int TW_FRAC   = 14;

  // Token carried alongside every sample through the delay lines.
  typedef struct packed {
    logic sof;
    logic inv;
  } fft_tag_t;

  // cos(2*pi*e/16) in Q2.14
  function automatic logic signed [TW_W-1:0] tw_cos(input logic [2:0] e);
    case (e)
      3'd0:    tw_cos = 16'sd16384;
      3'd1:    tw_cos = 16'sd15137;
      3'd2:    tw_cos = 16'sd11585;
      3'd3:    tw_cos = 16'sd6270;
      3'd4:    tw_cos = 16'sd0;
      3'd5:    tw_cos = -16'sd6270;
      3'd6:    tw_cos = -16'sd11585;
      default: tw_cos = -16'sd15137;
    endcase
  endfunction

  // sin(2*pi*e/16) in Q2.14
  function automatic logic signed [TW_W-1:0] tw_sin(input logic [2:0] e);
    case (e)
      3'd0:    tw_sin = 16'sd0;
      3'd1:    tw_sin = 16'sd6270;
      3'd2:    tw_sin = 16'sd11585;
      3'd3:    tw_sin = 16'sd15137;
      3'd4:    tw_sin = 16'sd16384;
      3'd5:    tw_sin = 16'sd15137;
      3'd6:    tw_sin = 16'sd11585;
      default: tw_sin = 16'sd6270;
    endcase
  endfunction

endpackage

// File: rtl/fft16_cmul.sv
module fft16_cmul
  import fft16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                en,
  input  logic [2:0]          e,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  output logic signed [W-1:0] y_re,
  output logic signed [W-1:0] y_im
);

  localparam int PW = W + TW_W + 1;
  localparam logic signed [PW-1:0] RND = PW'(2 ** (TW_FRAC - 1));

  logic signed [PW-1:0] ar, ai, wc, ws, pr, pi;

  // (a + jb)(c - js) = (ac + bs) + j(bc - as)
  always_comb begin
    ar = PW'(a_re);
    ai = PW'(a_im);
    wc = PW'(tw_cos(e));
    ws = PW'(tw_sin(e));
    pr = ar * wc + ai * ws + RND;
    pi = ai * wc - ar * ws + RND;
    if (en) begin
      y_re = W'(pr >>> TW_FRAC);
      y_im = W'(pi >>> TW_FRAC);
    end else begin
      y_re = a_re;
      y_im = a_im;
    end
  end

endmodule

// File: rtl/fft16_sdf_stage.sv
module fft16_sdf_stage
  import fft16_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int STAGE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic signed [W-1:0] x_re,
  input  logic signed [W-1:0] x_im,
  input  fft_tag_t            x_tag,
  output logic signed [W-1:0] y_re,
  output logic signed [W-1:0] y_im,
  output fft_tag_t            y_tag
);

  localparam int CW = $clog2(2 * DEPTH);

  logic [CW-1:0]       cnt_q, cnt_d, phase;
  logic                comp;
  logic signed [W-1:0] dre_q [DEPTH];
  logic signed [W-1:0] dim_q [DEPTH];
  fft_tag_t            tag_q [DEPTH];
  logic signed [W-1:0] fb_re, fb_im, bf_re, bf_im, rot_re, rot_im;

  // a frame start restarts the block phase
  assign phase = x_tag.sof ? '0 : cnt_q;
  assign comp  = phase[CW-1];

  always_comb begin
    cnt_d = phase + CW'(1);
    if (comp) begin
      bf_re = dre_q[DEPTH-1] + x_re;
      bf_im = dim_q[DEPTH-1] + x_im;
      fb_re = dre_q[DEPTH-1] - x_re;
      fb_im = dim_q[DEPTH-1] - x_im;
    end else begin
      bf_re = dre_q[DEPTH-1];
      bf_im = dim_q[DEPTH-1];
      fb_re = x_re;
      fb_im = x_im;
    end
  end

  // rotation of the drained differences; variant picked by delay depth
  generate
    if (DEPTH >= 4) begin : g_mul
      logic [2:0] tw_e;
      assign tw_e = 3'(phase[CW-2:0]) << STAGE;
      fft16_cmul #(.W(W)) u_cmul (
        .en   (!comp),
        .e    (tw_e),
        .a_re (bf_re),
        .a_im (bf_im),
        .y_re (rot_re),
        .y_im (rot_im)
      );
    end else if (DEPTH == 2) begin : g_swap
      logic [2:0] tw_e;
      logic       minus_j;
      assign tw_e    = 3'(phase[CW-2:0]) << STAGE;
      assign minus_j = !comp && (tw_e == 3'd4);
      assign rot_re  = minus_j ? bf_im : bf_re;
      assign rot_im  = minus_j ? -bf_re : bf_im;
    end else begin : g_none
      assign rot_re = bf_re;
      assign rot_im = bf_im;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      y_re  <= '0;
      y_im  <= '0;
      y_tag <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dre_q[i] <= '0;
        dim_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else if (adv) begin
      cnt_q <= cnt_d;
      y_re  <= rot_re;
      y_im  <= rot_im;
      y_tag <= tag_q[DEPTH-1];
      for (int i = DEPTH - 1; i > 0; i--) begin
        dre_q[i] <= dre_q[i-1];
        dim_q[i] <= dim_q[i-1];
        tag_q[i] <= tag_q[i-1];
      end
      dre_q[0] <= fb_re;
      dim_q[0] <= fb_im;
      tag_q[0] <= x_tag;
    end
  end

  // R5
  sof_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && tag_q[DEPTH-1].sof |-> comp);

endmodule

// File: rtl/fft16_sdf.sv
module fft16_sdf
  import fft16_pkg::*;
#(
  parameter int IN_W = 12,
  localparam int OUT_W = IN_W + FFT_LOG2N
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_inv,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);

  localparam int LAT = FFT_N - 1 + FFT_LOG2N - 1;
  localparam int FW  = $clog2(LAT + 1);

  logic rst_meta, rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic signed [OUT_W-1:0] st_re  [FFT_LOG2N+1];
  logic signed [OUT_W-1:0] st_im  [FFT_LOG2N+1];
  fft_tag_t                st_tag [FFT_LOG2N+1];
  logic signed [OUT_W-1:0] x_re_w, x_im_w;

  assign x_re_w    = OUT_W'(in_re);
  assign x_im_w    = OUT_W'(in_im);
  assign st_re[0]  = x_re_w;
  assign st_im[0]  = in_inv ? -x_im_w : x_im_w;
  assign st_tag[0] = '{sof: in_sof, inv: in_inv};

  generate
    for (genvar s = 0; s < FFT_LOG2N; s++) begin : g_stage
      fft16_sdf_stage #(
        .W     (OUT_W),
        .DEPTH (FFT_N >> (s + 1)),
        .STAGE (s)
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_ns),
        .adv   (in_valid),
        .x_re  (st_re[s]),
        .x_im  (st_im[s]),
        .x_tag (st_tag[s]),
        .y_re  (st_re[s+1]),
        .y_im  (st_im[s+1]),
        .y_tag (st_tag[s+1])
      );
    end
  endgenerate

  logic [FW-1:0] fill_q, fill_d;
  logic          vld_q, vld_d;

  always_comb begin
    fill_d = fill_q;
    if (in_valid && fill_q != FW'(LAT)) fill_d = fill_q + FW'(1);
    vld_d = in_valid && (fill_q == FW'(LAT));
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      fill_q <= fill_d;
      vld_q  <= vld_d;
    end
  end

  assign out_valid = vld_q;
  assign out_sof   = vld_q & st_tag[FFT_LOG2N].sof;
  assign out_re    = st_re[FFT_LOG2N];
  assign out_im    = st_tag[FFT_LOG2N].inv ? -st_im[FFT_LOG2N] : st_im[FFT_LOG2N];

  // output position tracking used only by the frame-marker property
  logic [FFT_LOG2N-1:0] opos_q;
  logic                 oseen_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      opos_q  <= '0;
      oseen_q <= 1'b0;
    end else if (out_valid) begin
      opos_q  <= out_sof ? FFT_LOG2N'(1) : opos_q + FFT_LOG2N'(1);
      oseen_q <= oseen_q | out_sof;
    end
  end

  // R8
  valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    out_valid |-> $past(in_valid));

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_valid |=> !out_valid && $stable(out_re) && $stable(out_im));

  // R5
  sof_spacing_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    out_valid && oseen_q |-> (out_sof == (opos_q == '0)));

endmodule

// File: tb/fft16_sdf_tb_top.sv
module fft16_sdf_tb_top;

  localparam int  IN_W  = 12;
  localparam int  OUT_W = IN_W + 4;
  localparam int  NPT   = 16;
  localparam int  LAT   = 18;
  localparam real TOL   = 16.0;
  localparam real PI    = 3.14159265358979;

  logic clk;
  logic rst_n;
  logic in_valid, in_sof, in_inv;
  logic signed [IN_W-1:0]  in_re, in_im;
  logic                    out_valid, out_sof;
  logic signed [OUT_W-1:0] out_re, out_im;

  fft16_sdf #(.IN_W(IN_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_inv    (in_inv),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int acc   = 0;
  int last_k = -1;
  bit started = 0;
  int xre[$];
  int xim[$];
  bit xinv[$];
  logic signed [OUT_W-1:0] prev_re, prev_im;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int bitrev4(input int v);
    return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
  endfunction

  function automatic void ref_bin(input int f, input int k, input bit inv,
                                  output real rr, output real ri);
    real sgn;
    sgn = inv ? 1.0 : -1.0;
    rr = 0.0;
    ri = 0.0;
    for (int n = 0; n < NPT; n++) begin
      real ang, c, s;
      ang = sgn * 2.0 * PI * real'(n * k) / real'(NPT);
      c = $cos(ang);
      s = $sin(ang);
      rr += real'(xre[f*NPT+n]) * c - real'(xim[f*NPT+n]) * s;
      ri += real'(xre[f*NPT+n]) * s + real'(xim[f*NPT+n]) * c;
    end
  endfunction

  function automatic bit close(input int act, input real expv);
    real d;
    d = real'(act) - expv;
    return (d <= TOL) && (d >= -TOL);
  endfunction

  task automatic check_outputs();
    if (last_k < 0) begin
      chk(out_valid == 1'b0, "R7", "out_valid during stall", int'(out_valid), 0);
      if (started)
        chk(out_re == prev_re && out_im == prev_im, "R7", "held real part",
            int'(out_re), int'(prev_re));
    end else if (last_k < LAT) begin
      chk(out_valid == 1'b0, "R8", "out_valid while filling", int'(out_valid), 0);
    end else begin
      int p, f, pos, bin;
      real er, ei;
      bit inv;
      p   = last_k - LAT;
      f   = p / NPT;
      pos = p % NPT;
      bin = bitrev4(pos);
      inv = xinv[f*NPT];
      ref_bin(f, bin, inv, er, ei);
      chk(out_valid == 1'b1, "R8", "out_valid after accept", int'(out_valid), 1);
      chk(out_sof == (pos == 0), "R5", "out_sof marker", int'(out_sof), int'(pos == 0));
      if (pos == 0)
        chk(out_valid && out_sof, "R4", "frame head timing", int'(out_sof), 1);
      if (inv) begin
        chk(close(int'(out_re), er), "R6", "inverse real", int'(out_re), $rtoi(er));
        chk(close(int'(out_im), ei), "R6", "inverse imag", int'(out_im), $rtoi(ei));
      end else begin
        chk(close(int'(out_re), er), "R2", "forward real", int'(out_re), $rtoi(er));
        chk(close(int'(out_im), ei), "R2", "forward imag", int'(out_im), $rtoi(ei));
      end
      if (pos == 1 || pos == 3)
        chk(close(int'(out_re), er) && close(int'(out_im), ei), "R3",
            "bit-reversed position", pos, bin);
    end
    prev_re = out_re;
    prev_im = out_im;
  endtask

  task automatic step(input bit v, input bit sof, input bit inv, input int re, input int im);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_sof   = v & sof;
    in_inv   = v & inv;
    in_re    = v ? IN_W'(re) : '0;
    in_im    = v ? IN_W'(im) : '0;
    if (v) begin
      xre.push_back(re);
      xim.push_back(im);
      xinv.push_back(inv);
      last_k = acc;
      acc++;
    end else begin
      last_k = -1;
    end
  endtask

  // kind: 0 impulse, 1 constant, 2 tone, 3 random, 4 near full scale, 5 zeros
  task automatic send_frame(input int kind, input bit inv, input bit gaps, input int tone);
    for (int n = 0; n < NPT; n++) begin
      int re, im;
      case (kind)
        0: begin re = (n == 0) ? 1000 : 0; im = (n == 0) ? -500 : 0; end
        1: begin re = 300; im = -200; end
        2: begin
          re = $rtoi(1200.0 * $cos(2.0 * PI * real'(tone * n) / real'(NPT)));
          im = $rtoi(1200.0 * $sin(2.0 * PI * real'(tone * n) / real'(NPT)));
        end
        3: begin re = int'($urandom_range(1600)) - 800; im = int'($urandom_range(1600)) - 800; end
        4: begin
          re = ($urandom_range(1) != 0) ? 1400 : -1400;
          im = ($urandom_range(1) != 0) ? 1400 : -1400;
        end
        default: begin re = 0; im = 0; end
      endcase
      if (gaps) begin
        int g;
        g = int'($urandom_range(2));
        for (int i = 0; i < g; i++) step(1'b0, 1'b0, 1'b0, 0, 0);
      end
      step(1'b1, n == 0, inv, re, im);
    end
  endtask

  initial begin
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_inv   = 1'b0;
    in_re    = '0;
    in_im    = '0;
    rst_n    = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid == 1'b0 && out_sof == 1'b0, "R1", "flags in reset", int'(out_valid), 0);
    chk(out_re == '0 && out_im == '0, "R1", "data in reset", int'(out_re), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_re == '0 && out_im == '0, "R1", "after release",
        int'(out_valid), 0);
    prev_re = out_re;
    prev_im = out_im;
    started = 1;
    step(1'b0, 1'b0, 1'b0, 0, 0);
    send_frame(0, 1'b0, 1'b0, 0);
    send_frame(1, 1'b0, 1'b0, 0);
    send_frame(2, 1'b0, 1'b0, 3);
    send_frame(3, 1'b0, 1'b0, 0);
    send_frame(2, 1'b1, 1'b0, 5);
    send_frame(3, 1'b1, 1'b0, 0);
    send_frame(3, 1'b0, 1'b1, 0);
    send_frame(4, 1'b0, 1'b0, 0);
    send_frame(4, 1'b1, 1'b1, 0);
    send_frame(5, 1'b0, 1'b0, 0);
    send_frame(5, 1'b0, 1'b1, 0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule